// File: doc/BRIEF.md
# Serial EEPROM Write Receiver

This block is the receive side of a two-wire serial memory slave. The bus clock and data lines are sampled with the faster system clock. The block finds start and stop conditions on the bus. It compares each control byte with a fixed device type and with three strap pins. After a write control byte it collects a two-byte word address and any number of data bytes, and it acknowledges each byte by pulling the data line low.

Every data byte it accepts is passed, together with its word address, to a downstream page-write engine as a one-cycle valid pulse. The word address advances by one after each byte. The advance wraps inside the current page, so a long burst overwrites the start of that page.

While the engine reports busy, the block does not acknowledge any control byte. A host can therefore keep sending its own address and treat the first acknowledge as the sign that the write cycle has finished.

Top module: `eeprom_wr_frontend`

## Requirements
- R1: A start (SDA falls while SCL is high) begins reception of a control byte. A stop (SDA rises while SCL is high) ends the transfer, and the SDA pull is released within two system clocks of a detected stop.
- R2: A control byte acknowledges during the ninth SCL pulse when all of these hold: its bits 7..4 equal 1010, its bits 3..1 equal `dev_strap[2:0]`, and `engine_busy` is low.
- R3: A control byte that fails the match gets no acknowledge. Every later byte is ignored until the next start: no acknowledge and no write strobe.
- R4: While `engine_busy` is high at the control-byte decision, no acknowledge is given, even to a matching address.
- R5: After a matching write control byte (bit 0 = 0), two address bytes follow, high byte first, and each is acknowledged. Bit 7 of the high byte is discarded, which gives a 15-bit word address.
- R6: Each data byte after the address is acknowledged and produces exactly one single-cycle `wr_valid` pulse. The pulse carries the byte (MSB received first) on `wr_data` and its word address on `wr_addr`.
- R7: After each data byte, the word address increments in its low 6 bits only, so it wraps within a 64-byte page. Bits 14..6 are kept.
- R8: A start that arrives in the middle of a transfer discards the partial transfer and restarts control-byte reception.
- R9: A matching control byte with bit 0 = 1 (read) is acknowledged, and no write strobe follows it.
- R10: `sda_pull_low` changes only while the synchronized SCL is low.
- R11: During reset, `sda_pull_low` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| dev_strap | input | 3 | Device select straps compared with control bits 3..1 |
| engine_busy | input | 1 | Downstream write cycle in progress |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_valid | output | 1 | One-cycle strobe for an accepted data byte |
| wr_addr | output | 15 | Word address of the strobed byte |
| wr_data | output | 8 | Data byte of the strobed byte |

## Verification
The assertions assume a well-behaved host. SDA changes only while SCL is low, except when it forms a start or a stop. Each SCL phase lasts several system clocks, longer than the synchronizer delay plus one cycle, so that data bytes never strobe on adjacent cycles. The bench host holds each SCL half-period for eight system clocks. It moves SDA only during the low phase, and it sets up a repeated start by raising SDA before raising SCL. It drives `engine_busy` only around a control byte, never in the middle of a data burst.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;

   localparam int BYTE_W = 8;
   localparam int BITCNT_W = 4;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_CTRL,
      RX_ADDR_HI,
      RX_ADDR_LO,
      RX_DATA,
      RX_SKIP
   } rx_state_t;

   typedef struct packed {
      logic ack;
      logic load_hi;
      logic load_lo;
      logic emit;
      logic ctrl_eval;
   } byte_action_t;

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
   parameter int W = 2,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("bus_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/word_addr_ctr.sv
module word_addr_ctr #(
   parameter int ADDR_W = 15,
   parameter int PAGE_W = 6,
   parameter bit WRAP_PAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_we,
   input  logic              lo_we,
   input  logic              step,
   input  logic [7:0]        byte_in,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int HI_W = ADDR_W - 8;
   localparam logic [7:0] HI_MASK = 8'((1 << HI_W) - 1);

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("word_addr_ctr: ADDR_W must be 9..16");
      end
      if (PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_page
         $error("word_addr_ctr: PAGE_W out of range");
      end
   endgenerate

   logic [7:0]        hi_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_next;

   generate
      if (WRAP_PAGE && PAGE_W < ADDR_W) begin : g_wrap
         always_comb begin
            addr_next = addr_q;
            addr_next[PAGE_W-1:0] = addr_q[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};
         end
      end else begin : g_linear
         always_comb addr_next = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         addr_q <= '0;
      end else begin
         if (hi_we) hi_q <= byte_in & HI_MASK;
         if (lo_we) addr_q <= ADDR_W'({hi_q, byte_in});
         else if (step) addr_q <= addr_next;
      end
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/wr_rx_fsm.sv
module wr_rx_fsm
   import eeprom_wr_pkg::*;
#(
   parameter int STRAP_W = 3,
   parameter logic [3:0] TYPE_CODE = 4'b1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic               sda_s,
   input  logic [STRAP_W-1:0] strap,
   input  logic               busy,
   output logic               pull_low,
   output logic               hi_we,
   output logic               lo_we,
   output logic               emit,
   output logic               ctrl_decide,
   output logic [7:0]         rx_byte
);

   generate
      if (STRAP_W != 3) begin : g_bad_strap
         $error("wr_rx_fsm: control byte holds exactly three strap bits");
      end
   endgenerate

   rx_state_t     state_q, state_n;
   logic [BITCNT_W-1:0] bitcnt_q;
   logic          ack_phase_q;
   logic [7:0]    shreg_q;
   byte_action_t  act;
   logic          ctrl_match;
   logic          byte_done;

   assign byte_done  = scl_fall && !ack_phase_q && (bitcnt_q == 4'd8);
   assign ctrl_match = (shreg_q[7:4] == TYPE_CODE) && (shreg_q[3:1] == strap) && !busy;

   always_comb begin
      act     = '0;
      state_n = state_q;
      unique case (state_q)
         RX_CTRL: begin
            act.ctrl_eval = 1'b1;
            act.ack       = ctrl_match;
            state_n       = (ctrl_match && !shreg_q[0]) ? RX_ADDR_HI : RX_SKIP;
         end
         RX_ADDR_HI: begin
            act.ack     = 1'b1;
            act.load_hi = 1'b1;
            state_n     = RX_ADDR_LO;
         end
         RX_ADDR_LO: begin
            act.ack     = 1'b1;
            act.load_lo = 1'b1;
            state_n     = RX_DATA;
         end
         RX_DATA: begin
            act.ack  = 1'b1;
            act.emit = 1'b1;
         end
         RX_SKIP: state_n = RX_SKIP;
         default: state_n = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= RX_IDLE;
         bitcnt_q    <= '0;
         ack_phase_q <= 1'b0;
         shreg_q     <= '0;
         pull_low    <= 1'b0;
         hi_we       <= 1'b0;
         lo_we       <= 1'b0;
         emit        <= 1'b0;
         ctrl_decide <= 1'b0;
      end else begin
         hi_we       <= 1'b0;
         lo_we       <= 1'b0;
         emit        <= 1'b0;
         ctrl_decide <= 1'b0;
         if (stop_det) begin
            state_q     <= RX_IDLE;
            bitcnt_q    <= '0;
            ack_phase_q <= 1'b0;
            pull_low    <= 1'b0;
         end else if (start_det) begin
            state_q     <= RX_CTRL;
            bitcnt_q    <= '0;
            ack_phase_q <= 1'b0;
            pull_low    <= 1'b0;
         end else if (state_q != RX_IDLE) begin
            if (scl_rise && !ack_phase_q && bitcnt_q < 4'd8) begin
               shreg_q  <= {shreg_q[6:0], sda_s};
               bitcnt_q <= bitcnt_q + 4'd1;
            end else if (byte_done) begin
               ack_phase_q <= 1'b1;
               pull_low    <= act.ack;
               state_q     <= state_n;
               hi_we       <= act.load_hi;
               lo_we       <= act.load_lo;
               emit        <= act.emit;
               ctrl_decide <= act.ctrl_eval;
            end else if (scl_fall && ack_phase_q) begin
               ack_phase_q <= 1'b0;
               bitcnt_q    <= '0;
               pull_low    <= 1'b0;
            end
         end
      end
   end

   assign rx_byte = shreg_q;

endmodule

// File: rtl/eeprom_wr_frontend.sv
module eeprom_wr_frontend
   import eeprom_wr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W = 15,
   parameter int PAGE_W = 6,
   parameter bit WRAP_PAGE = 1'b1,
   parameter int STRAP_W = 3,
   parameter logic [3:0] TYPE_CODE = 4'b1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   input  logic [STRAP_W-1:0] dev_strap,
   input  logic               engine_busy,
   output logic               sda_pull_low,
   output logic               wr_valid,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [7:0]         wr_data
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("eeprom_wr_frontend: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [1:0] lines_s;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, start_det, stop_det;
   logic       hi_we, lo_we, emit, ctrl_decide;
   logic [7:0] rx_byte;
   logic [ADDR_W-1:0] cur_addr;

   bus_line_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({scl_in, sda_in}),
      .q_out (lines_s)
   );

   assign scl_s = lines_s[1];
   assign sda_s = lines_s[0];

   bus_cond_detect u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   wr_rx_fsm #(.STRAP_W(STRAP_W), .TYPE_CODE(TYPE_CODE)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .start_det   (start_det),
      .stop_det    (stop_det),
      .sda_s       (sda_s),
      .strap       (dev_strap),
      .busy        (engine_busy),
      .pull_low    (sda_pull_low),
      .hi_we       (hi_we),
      .lo_we       (lo_we),
      .emit        (emit),
      .ctrl_decide (ctrl_decide),
      .rx_byte     (rx_byte)
   );

   word_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRAP_PAGE(WRAP_PAGE)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .hi_we   (hi_we),
      .lo_we   (lo_we),
      .step    (emit),
      .byte_in (rx_byte),
      .addr_o  (cur_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= emit;
         if (emit) begin
            wr_addr <= cur_addr;
            wr_data <= rx_byte;
         end
      end
   end

endmodule

// File: rtl/eeprom_wr_frontend_chk.sv
module eeprom_wr_frontend_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_sync,
   input logic stop_det,
   input logic ctrl_decide,
   input logic engine_busy,
   input logic sda_pull_low,
   input logic wr_valid
);

   assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull_low);

   assert_busy_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_decide && engine_busy) |=> !sda_pull_low);

   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_low) |-> !$past(scl_sync));

endmodule

bind eeprom_wr_frontend eeprom_wr_frontend_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_sync     (scl_s),
   .stop_det     (stop_det),
   .ctrl_decide  (ctrl_decide),
   .engine_busy  (engine_busy),
   .sda_pull_low (sda_pull_low),
   .wr_valid     (wr_valid)
);

// File: tb/eeprom_wr_frontend_tb_top.sv
module eeprom_wr_frontend_tb_top;

   localparam int H = 8;
   localparam int NV = 8;
   // {ctrl, addr_hi, addr_lo, n_data, seed, busy, exp_ack}
   localparam logic [55:0] VEC [NV] = '{
      56'hAA_12_34_01_5A_00_01,
      56'hAA_85_00_02_C3_00_01,
      56'hA8_00_00_00_00_00_00,
      56'hBA_00_00_00_00_00_00,
      56'hAA_00_00_00_00_01_00,
      56'hAA_00_3E_03_10_00_01,
      56'hAB_00_00_00_00_00_01,
      56'hAA_7F_FF_01_E1_00_01
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic busy = 1'b0;
   logic [2:0] strap = 3'b101;
   logic sda_pull_low, wr_valid;
   logic [14:0] wr_addr;
   logic [7:0] wr_data;
   wire sda_bus = sda_m & ~sda_pull_low;

   always #10 clk = ~clk;

   eeprom_wr_frontend dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_in       (scl_m),
      .sda_in       (sda_bus),
      .dev_strap    (strap),
      .engine_busy  (busy),
      .sda_pull_low (sda_pull_low),
      .wr_valid     (wr_valid),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data)
   );

   int checks = 0;
   int errors = 0;
   int ev_cnt = 0;
   int pull_viol = 0;
   logic [14:0] ev_addr [64];
   logic [7:0]  ev_data [64];
   logic prev_pull = 1'b0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (rst_n && wr_valid && ev_cnt < 64) begin
         ev_addr[ev_cnt] = wr_addr;
         ev_data[ev_cnt] = wr_data;
         ev_cnt = ev_cnt + 1;
      end
      if (rst_n && sda_pull_low != prev_pull && scl_m) pull_viol = pull_viol + 1;
      prev_pull = sda_pull_low;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_h();
      repeat (H) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_h();
      scl_m = 1'b1; wait_h();
      sda_m = 1'b0; wait_h();
      scl_m = 1'b0; wait_h();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_h();
      scl_m = 1'b1; wait_h();
      sda_m = 1'b1; wait_h();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_h();
         scl_m = 1'b1; wait_h();
         scl_m = 1'b0;
      end
      sda_m = 1'b1; wait_h();
      scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      ack = ~sda_bus;
      repeat (H/2) @(negedge clk);
      scl_m = 1'b0; wait_h();
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         finish_run();
      end
   end

   initial begin
      bit ack;
      repeat (5) @(negedge clk);
      check(sda_pull_low == 1'b0, "R11 pull in reset", 32'(sda_pull_low), 0);
      check(wr_valid == 1'b0, "R11 strobe in reset", 32'(wr_valid), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         logic [7:0] c, ah, al, nd, sd, bz, ea;
         logic [14:0] base, ea_addr;
         int ev0;
         {c, ah, al, nd, sd, bz, ea} = VEC[k];
         ev0 = ev_cnt;
         busy = bz[0];
         bus_start();
         send_byte(c, ack);
         busy = 1'b0;
         check(ack == ea[0], "R2 R4 R9 control ack", 32'(ack), 32'(ea[0]));
         if (ack && !c[0]) begin
            send_byte(ah, ack);
            check(ack, "R5 addr hi ack", 32'(ack), 1);
            send_byte(al, ack);
            check(ack, "R5 addr lo ack", 32'(ack), 1);
            for (int d = 0; d < int'(nd); d++) begin
               send_byte(sd + 8'(d * 17), ack);
               check(ack, "R6 data ack", 32'(ack), 1);
            end
         end else if (!ack) begin
            send_byte(8'h00, ack);
            check(!ack, "R3 ignored byte", 32'(ack), 0);
         end
         bus_stop();
         repeat (4) @(negedge clk);
         check(sda_pull_low == 1'b0, "R1 released after stop", 32'(sda_pull_low), 0);
         if (ea[0] && !c[0]) begin
            check(ev_cnt - ev0 == int'(nd), "R6 strobe count", 32'(ev_cnt - ev0), 32'(nd));
            base = {ah[6:0], al};
            for (int d = 0; d < int'(nd); d++) begin
               ea_addr = {base[14:6], 6'(base[5:0] + 6'(d))};
               check(ev_addr[ev0 + d] == ea_addr, "R5 R7 strobe address", 32'(ev_addr[ev0 + d]), 32'(ea_addr));
               check(ev_data[ev0 + d] == sd + 8'(d * 17), "R6 strobe data", 32'(ev_data[ev0 + d]), 32'(sd + 8'(d * 17)));
            end
         end else begin
            check(ev_cnt == ev0, "R3 R9 no strobe", 32'(ev_cnt - ev0), 0);
         end
      end

      begin
         int ev0;
         ev0 = ev_cnt;
         bus_start();
         send_byte(8'hAA, ack);
         send_byte(8'h22, ack);
         bus_start();
         send_byte(8'hAA, ack);
         check(ack, "R8 ack after repeated start", 32'(ack), 1);
         send_byte(8'h01, ack);
         send_byte(8'h02, ack);
         send_byte(8'h77, ack);
         check(ack, "R8 data ack", 32'(ack), 1);
         bus_stop();
         repeat (4) @(negedge clk);
         check(ev_cnt - ev0 == 1, "R8 strobe count", 32'(ev_cnt - ev0), 1);
         check(ev_addr[ev0] == 15'h0102, "R8 address after restart", 32'(ev_addr[ev0]), 32'h0102);
         check(ev_data[ev0] == 8'h77, "R8 data after restart", 32'(ev_data[ev0]), 32'h77);
      end

      check(pull_viol == 0, "R10 pull edges only with SCL low", 32'(pull_viol), 0);
      done = 1'b1;
      finish_run();
   end

endmodule